// File: doc/BRIEF.md
# Zero-Power Memory Wrapper

This block sits in front of a synchronous RAM array and keeps the array in standby except for a short window after the host touches the bus. While chip select is high, any of the following wakes the array: a change of address from one clock to the next, the chip select itself rising, or a fresh rising edge on the read or write strobe. The array then stays enabled for a fixed number of clock cycles. At the end of that window the addressed word is loaded into an output latch, and the array drops back to standby without any help from the host. On a write, the data is stored at the captured address and the latch shows the written word.

The output latch drives the read data port at all times, so the host sees the last word that was accessed while the array itself is idle. The wrapper holds a fixed total number of bits. It can be built for an 8-bit or a 16-bit data bus: 2048 words of 8 bits, or 1024 words of 16 bits.

The controller has three states. SLEEP is standby. ACTIVE is the counted window. LATCH is one cycle in which the result is captured. The transitions are:
- SLEEP to ACTIVE on a wake.
- ACTIVE to ACTIVE with the window reloaded on a wake.
- ACTIVE to LATCH when the count runs out.
- LATCH to SLEEP when the capture is done.
- LATCH to ACTIVE on a wake.
- ACTIVE or LATCH to SLEEP, with nothing captured, when chip select falls.

Top module: `zpm_wrapper`

## Requirements
- R1: After reset, standby is 1, rdata is 0 and the controller is in SLEEP.
- R2: With cs high, standby goes to 0 after the clock edge at which the address differs from the previous cycle's address, cs has just risen, or rd_en or wr_en has just risen.
- R3: Once woken, standby stays 0 for exactly ACT_CYC+1 cycles (ACT_CYC in ACTIVE plus one in LATCH) and then returns to 1 with no further host action.
- R4: rdata changes only at the edge that ends the LATCH cycle, ACT_CYC+1 edges after the waking edge. For a read it then shows the word stored at the address captured at the last wake. It keeps that value throughout standby.
- R5: A wake during ACTIVE or LATCH restarts the window, and the data latched is that of the newest address.
- R6: While cs is 0, address or strobe activity causes no wake: standby stays 1 and rdata holds its value.
- R7: If cs falls during ACTIVE or LATCH, the controller returns to SLEEP on the next edge. Nothing is latched and no pending write is stored.
- R8: The array holds TOTAL_BITS/DATA_W words. With DATA_W=8 the address is 11 bits wide (2048 words), and with DATA_W=16 it is 10 bits wide (1024 words). Every address selects a distinct word.
- R9: If wr_en is high at the waking edge, or at any edge during ACTIVE, the most recently sampled wdata is written at the captured address in the LATCH cycle and appears on rdata at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| addr | input | AW | Word address (AW = log2(TOTAL_BITS/DATA_W)) |
| rd_en | input | 1 | Read strobe; a rising edge wakes the array |
| wr_en | input | 1 | Write strobe; requests a write in the window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Output latch contents |
| standby | output | 1 | 1 while the array is idle (state SLEEP) |

## Verification
The bench builds two copies of the wrapper, both with ACT_CYC=2. The main copy uses DATA_W=16, which gives 1024 words and a 10-bit address, and it covers the table of reads and writes, the cycle-exact window, restart, the cs-low cases, abort and strobe-only wakes. The second copy uses DATA_W=8, which gives 2048 words and an 11-bit address. On that copy the bench writes the top word and a word whose address differs only in the eleventh bit, so a truncated decoder would alias the two.

// File: rtl/zpm_pkg.sv
package zpm_pkg;
    typedef enum logic [1:0] {
        ZP_SLEEP  = 2'd0,
        ZP_ACTIVE = 2'd1,
        ZP_LATCH  = 2'd2
    } zp_state_e;
endpackage

// File: rtl/zpm_watch.sv
module zpm_watch #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    output logic          wake
);
    logic [AW-1:0] addr_q;
    logic          cs_q;
    logic          rd_q;
    logic          wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cs_q   <= 1'b0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            cs_q   <= cs;
            rd_q   <= rd_en;
            wr_q   <= wr_en;
        end
    end

    always_comb begin
        wake = cs && ((addr != addr_q) || !cs_q ||
                      (rd_en && !rd_q) || (wr_en && !wr_q));
    end
endmodule

// File: rtl/zpm_ctrl.sv
module zpm_ctrl
    import zpm_pkg::*;
#(
    parameter int ACT_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs,
    input  logic      wake,
    output zp_state_e state,
    output logic      arr_en,
    output logic      do_latch,
    output logic      standby
);
    localparam int CW = (ACT_CYC < 2) ? 1 : $clog2(ACT_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(ACT_CYC - 1);

    zp_state_e     nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ZP_SLEEP;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ZP_SLEEP: begin
                if (wake) begin
                    nxt     = ZP_ACTIVE;
                    cnt_nxt = RELOAD;
                end
            end
            ZP_ACTIVE: begin
                if (!cs) begin
                    nxt = ZP_SLEEP;
                end else if (wake) begin
                    cnt_nxt = RELOAD;
                end else if (cnt == '0) begin
                    nxt = ZP_LATCH;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ZP_LATCH: begin
                if (!cs) begin
                    nxt = ZP_SLEEP;
                end else if (wake) begin
                    nxt     = ZP_ACTIVE;
                    cnt_nxt = RELOAD;
                end else begin
                    nxt = ZP_SLEEP;
                end
            end
            default: nxt = ZP_SLEEP;
        endcase
    end

    always_comb begin
        standby  = (state == ZP_SLEEP);
        arr_en   = (state != ZP_SLEEP);
        do_latch = (state == ZP_LATCH) && cs && !wake;
    end
endmodule

// File: rtl/zpm_array.sv
module zpm_array #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/zpm_wrapper.sv
module zpm_wrapper
    import zpm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ACT_CYC    = 2,
    parameter int TOTAL_BITS = 16384,
    localparam int DEPTH     = TOTAL_BITS / DATA_W,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [AW-1:0]     addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              standby
);
    zp_state_e         state;
    logic              wake;
    logic              arr_en;
    logic              do_latch;
    logic [AW-1:0]     addr_hold;
    logic [DATA_W-1:0] wdata_hold;
    logic              wr_pend;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] latch_q;

    zpm_watch #(.AW(AW)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .wake  (wake)
    );

    zpm_ctrl #(.ACT_CYC(ACT_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .wake     (wake),
        .state    (state),
        .arr_en   (arr_en),
        .do_latch (do_latch),
        .standby  (standby)
    );

    zpm_array #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .en    (arr_en),
        .we    (do_latch && wr_pend),
        .addr  (addr_hold),
        .wdata (wdata_hold),
        .rdata (arr_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold  <= '0;
            wdata_hold <= '0;
            wr_pend    <= 1'b0;
            latch_q    <= '0;
        end else begin
            if (wake) begin
                addr_hold  <= addr;
                wr_pend    <= wr_en;
                wdata_hold <= wdata;
            end else if ((state == ZP_ACTIVE) && cs && wr_en) begin
                wr_pend    <= 1'b1;
                wdata_hold <= wdata;
            end
            if (do_latch) begin
                latch_q <= wr_pend ? wdata_hold : arr_rd;
            end
        end
    end

    assign rdata = latch_q;
endmodule

// File: rtl/zpm_checker.sv
module zpm_checker #(
    parameter int ACT_CYC = 2,
    parameter int DW      = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          wake,
    input logic          standby,
    input logic [DW-1:0] rdata
);
    localparam int RW = $clog2(ACT_CYC + 2) + 1;
    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (wake || standby) begin
            run <= '0;
        end else if (int'(run) <= ACT_CYC) begin
            run <= run + 1'b1;
        end
    end

    p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !standby);

    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |-> (int'(run) <= ACT_CYC));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !wake) |=> $stable(rdata));

    p_cs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> standby);
endmodule

bind zpm_wrapper zpm_checker #(.ACT_CYC(ACT_CYC), .DW(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .wake    (wake),
    .standby (standby),
    .rdata   (rdata)
);

// File: tb/zpm_wrapper_bench.sv
module zpm_wrapper_bench;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic        we;
        logic [9:0]  a;
        logic [15:0] d;
        logic [15:0] e;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{1'b1, 10'h005, 16'hA1B2, 16'hA1B2},
        '{1'b1, 10'h3FF, 16'h1234, 16'h1234},
        '{1'b1, 10'h000, 16'hFFFF, 16'hFFFF},
        '{1'b0, 10'h005, 16'h0000, 16'hA1B2},
        '{1'b0, 10'h3FF, 16'h0000, 16'h1234},
        '{1'b1, 10'h005, 16'h5A5A, 16'h5A5A},
        '{1'b0, 10'h000, 16'h0000, 16'hFFFF},
        '{1'b0, 10'h005, 16'h0000, 16'h5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic [9:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        standby;

    logic        cs8 = 1'b0;
    logic [10:0] addr8 = '0;
    logic        rd8 = 1'b0;
    logic        wr8 = 1'b0;
    logic [7:0]  wd8 = '0;
    logic [7:0]  rd8_q;
    logic        sb8;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    zpm_wrapper #(.DATA_W(16), .ACT_CYC(2)) u_zpm_wrapper (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .standby(standby)
    );

    zpm_wrapper #(.DATA_W(8), .ACT_CYC(2)) u_zpm_wrapper_b8 (
        .clk(clk), .rst_n(rst_n), .cs(cs8), .addr(addr8), .rd_en(rd8),
        .wr_en(wr8), .wdata(wd8), .rdata(rd8_q), .standby(sb8)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc(input logic we, input logic [9:0] a, input logic [15:0] d);
        cs = 1'b1; addr = a; wr_en = we; rd_en = !we; wdata = d;
        step(1);
        wr_en = 1'b0; rd_en = 1'b0;
        step(4);
    endtask

    task automatic acc8(input logic we, input logic [10:0] a, input logic [7:0] d);
        cs8 = 1'b1; addr8 = a; wr8 = we; rd8 = !we; wd8 = d;
        step(1);
        wr8 = 1'b0; rd8 = 1'b0;
        step(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 standby", {15'd0, standby}, 16'd1);
        chk("R1 rdata", rdata, 16'h0000);

        // R4 R9 table of reads and writes
        for (int i = 0; i < 8; i++) begin
            acc(VT[i].we, VT[i].a, VT[i].d);
            chk(VT[i].we ? "R9 write latch" : "R4 read data", rdata, VT[i].e);
        end

        // R3 R4 cycle-exact window on a write to 0x010
        addr = 10'h010; wr_en = 1'b1; wdata = 16'h0F0F;
        step(1);
        wr_en = 1'b0;
        chk("R3 low cycle 1", {15'd0, standby}, 16'd0);
        step(1);
        chk("R3 low cycle 2", {15'd0, standby}, 16'd0);
        step(1);
        chk("R3 low cycle 3", {15'd0, standby}, 16'd0);
        chk("R4 rdata before latch", rdata, 16'h5A5A);
        step(1);
        chk("R3 back to standby", {15'd0, standby}, 16'd1);
        chk("R4 R9 rdata after latch", rdata, 16'h0F0F);
        step(2);
        chk("R4 rdata held", rdata, 16'h0F0F);

        // R5 restart: newest address wins
        acc(1'b1, 10'h020, 16'h1111);
        acc(1'b1, 10'h021, 16'h2222);
        addr = 10'h020; rd_en = 1'b1;
        step(1);
        addr = 10'h021;
        step(1);
        rd_en = 1'b0;
        step(3);
        chk("R5 restart standby", {15'd0, standby}, 16'd1);
        chk("R5 restart data", rdata, 16'h2222);

        // R6 cs low: no wake
        cs = 1'b0; addr = 10'h020; rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
        chk("R6 standby 1", {15'd0, standby}, 16'd1);
        addr = 10'h3FF;
        step(1);
        chk("R6 standby 2", {15'd0, standby}, 16'd1);
        step(3);
        chk("R6 rdata held", rdata, 16'h2222);

        // R2 cs rise alone wakes (address unchanged)
        addr = 10'h020;
        step(2);
        cs = 1'b1;
        step(1);
        chk("R2 cs rise wake", {15'd0, standby}, 16'd0);
        step(3);
        chk("R2 cs rise data", rdata, 16'h1111);

        // R7 abort: cs falls in window, write discarded
        addr = 10'h022; wr_en = 1'b1; wdata = 16'hBEEF;
        step(1);
        cs = 1'b0; wr_en = 1'b0;
        step(1);
        chk("R7 abort standby", {15'd0, standby}, 16'd1);
        step(3);
        chk("R7 abort rdata", rdata, 16'h1111);
        acc(1'b0, 10'h020, 16'h0);
        chk("R7 no write done", rdata, 16'h1111);

        // R2 strobe rise alone wakes (cs steady, same address)
        acc(1'b1, 10'h020, 16'h7777);
        chk("R2 R9 strobe wake write", rdata, 16'h7777);
        acc(1'b0, 10'h020, 16'h0);
        chk("R2 strobe wake read", rdata, 16'h7777);

        // R8 8-bit organisation: 2048 words, 11-bit address
        acc8(1'b1, 11'h7FF, 8'hA5);
        acc8(1'b1, 11'h3FF, 8'h11);
        acc8(1'b1, 11'h400, 8'h3C);
        acc8(1'b0, 11'h7FF, 8'h00);
        chk("R8 top word", {8'd0, rd8_q}, 16'h00A5);
        acc8(1'b0, 11'h400, 8'h00);
        chk("R8 upper half", {8'd0, rd8_q}, 16'h003C);
        acc8(1'b0, 11'h3FF, 8'h00);
        chk("R8 lower half", {8'd0, rd8_q}, 16'h0011);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule